// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked host read and write a byte-wide asynchronous static RAM with 32K locations. The host hands over one access at a time through a request pulse. It gives the 15-bit location, a direction flag and, for a store, the byte to store. The block answers with a one-cycle ready pulse. When a load completes, the fetched byte is on the read-data output in that same cycle.

On the memory side the block drives the active-low select, output-enable and write-strobe lines and the address bus. The data bus is split into an outgoing byte, a drive-enable and an incoming byte, so the pad ring can build the bidirectional pin. Every access is cut into whole clock cycles. A store runs through setup, strobe and hold. A load runs through an access wait and then a bus-release gap. Each phase length is computed at elaboration from the clock period and the memory's speed grade (12, 15 or 20 ns). Each length is rounded up to whole cycles, with a minimum of one. When the block is idle the memory is deselected.

The values quoted below hold for the default parameters: a 5 ns clock and the 15 ns grade. With these, setup is 1 cycle, strobe is 3, hold is 1, the load wait is 3 and the release gap is 2.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever idle, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `host_ready` is 0.
- R2: A store (`host_we`=1) holds `mem_we_n` low for exactly 3 consecutive cycles. During that time `mem_ce_n` is 0 and `mem_oe_n` is 1, and the memory receives `host_wdata` at the location `host_addr`.
- R3: In a store, `mem_ce_n` is low and `mem_dq_oe` is high for at least one cycle before `mem_we_n` falls. Both still hold in the cycle after `mem_we_n` rises.
- R4: While `mem_ce_n` stays low, `mem_addr` and `mem_dq_out` do not change.
- R5: A load (`host_we`=0) holds `mem_ce_n` and `mem_oe_n` low, `mem_we_n` high and `mem_dq_oe` low for exactly 3 cycles. The incoming byte is captured on the edge that ends this wait, and `host_rdata` presents it while `host_ready` is high.
- R6: `mem_dq_oe` is never high while `mem_oe_n` is low. After a load, `mem_oe_n` stays high for at least 2 cycles before `mem_dq_oe` can rise.
- R7: `host_ready` is high for exactly one cycle per access. It rises on the 5th rising edge after the accepting edge for a store, and on the 3rd for a load.
- R8: `host_req` is taken only in the idle state. A request during a load's ready cycle is ignored and starts no memory cycle. A request during a store's ready cycle is accepted on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, sampled only when idle |
| host_we | input | 1 | 1 = store, 0 = load |
| host_addr | input | 15 | Location to access |
| host_wdata | input | 8 | Byte to store |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Byte fetched by the latest load |
| mem_addr | output | 15 | Memory address bus |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Byte returned by the memory |

## Verification
Two events can meet in one cycle: the completion pulse of one access and the arrival of the next request. The bench raises a new request in the very cycle it sees `host_ready`. After a store, that request must start a load on the same edge, and the load must return the byte just stored. After a load, the block is still releasing the bus, so the same request must vanish: the bench watches that `mem_ce_n` stays high, that no further ready appears, and that memory contents are unchanged. A memory model answers with a poison byte until its own access delay has passed. An early capture, or driving the data bus during the release gap, shows up as a mismatch at the ports.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared state type and elaboration-time timing arithmetic for the
// asynchronous SRAM sequencer. Times are in picoseconds; grades are 12/15/20.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WSTROBE,
        ST_WHOLD,
        ST_RWAIT,
        ST_RTURN
    } ctrl_state_t;

    // Whole cycles covering a time, never fewer than one.
    function automatic int cyc_of(input int ps, input int clk_ps);
        int c;
        if (ps <= 0) return 1;
        c = (ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Minimum write strobe low time.
    function automatic int strobe_ps(input int grade);
        case (grade)
            12:      return 10000;
            15:      return 12000;
            default: return 15000;
        endcase
    endfunction

    // Data valid before strobe rises.
    function automatic int dsetup_ps(input int grade);
        case (grade)
            12:      return 7000;
            15:      return 8000;
            default: return 10000;
        endcase
    endfunction

    // Full write cycle and address access time (equal per grade).
    function automatic int cycle_ps(input int grade);
        case (grade)
            12:      return 12000;
            15:      return 15000;
            default: return 20000;
        endcase
    endfunction

    // Output-enable access time.
    function automatic int oe_access_ps(input int grade);
        case (grade)
            12:      return 6000;
            15:      return 7000;
            default: return 8000;
        endcase
    endfunction

    // Time for the memory to float its outputs after output enable rises.
    function automatic int release_ps(input int grade);
        case (grade)
            12:      return 6000;
            15:      return 7000;
            default: return 8000;
        endcase
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Phase timer: a down counter loaded with (length-1) on phase entry; zero
// marks the last cycle of the current phase. Assumes load has priority.
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Count down the remaining cycles of the active phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_host_latch.sv
// Host-side registers: freezes address and store byte when an access is
// accepted, and captures the memory byte on the load sample edge. Assumes
// accept and sample never coincide (the sequencer guarantees this).
module sram_host_latch #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              sample,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    // Hold address and store byte stable for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    // Capture the fetched byte at the end of the load wait.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (sample)
            rdata_q <= dq_in;
    end

endmodule

// File: rtl/sram_access_fsm.sv
// Access sequencer: walks store (setup, strobe, hold) and load (wait,
// release) phases, loading the phase timer at each entry, and raises a
// one-cycle ready pulse. Assumes every *_CYC parameter is at least one.
module sram_access_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W      = 2,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1,
    parameter int READ_CYC   = 3,
    parameter int TURN_CYC   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             sample,
    output logic             ready,
    output ctrl_state_t      state
);

    localparam logic [CNT_W-1:0] SETUP_V  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_V = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_V   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] READ_V   = CNT_W'(READ_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_V   = CNT_W'(TURN_CYC - 1);

    ctrl_state_t state_d;
    logic        ready_d;

    // Next-state and phase-length selection.
    always_comb begin
        state_d  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        sample   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_we) begin
                        state_d = ST_WSETUP;
                        tmr_val = SETUP_V;
                    end else begin
                        state_d = ST_RWAIT;
                        tmr_val = READ_V;
                    end
                end
            end
            ST_WSETUP: begin
                if (tmr_zero) begin
                    state_d  = ST_WSTROBE;
                    tmr_load = 1'b1;
                    tmr_val  = STROBE_V;
                end
            end
            ST_WSTROBE: begin
                if (tmr_zero) begin
                    state_d  = ST_WHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_V;
                end
            end
            ST_WHOLD: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            ST_RWAIT: begin
                if (tmr_zero) begin
                    sample   = 1'b1;
                    state_d  = ST_RTURN;
                    tmr_load = 1'b1;
                    tmr_val  = TURN_V;
                end
            end
            ST_RTURN: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign ready_d = sample || ((state == ST_WHOLD) && tmr_zero);

    // State register and registered completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ready <= 1'b0;
        end else begin
            state <= state_d;
            ready <= ready_d;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Top: synchronous host port to an asynchronous byte-wide SRAM. Phase lengths
// come from CLK_PS and GRADE_NS at elaboration. Memory pins decode from the
// state register only, so they change just after a clock edge. Assumes the
// host waits for ready before issuing its next request.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int CLK_PS   = 5000,
    parameter int GRADE_NS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int SETUP_CYC  = cyc_of(0, CLK_PS);
    localparam int STROBE_CYC = cyc_of(imax(strobe_ps(GRADE_NS), dsetup_ps(GRADE_NS)), CLK_PS);
    localparam int HOLD_CYC   = cyc_of(cycle_ps(GRADE_NS) - (SETUP_CYC + STROBE_CYC) * CLK_PS, CLK_PS);
    localparam int READ_CYC   = cyc_of(imax(cycle_ps(GRADE_NS), oe_access_ps(GRADE_NS)), CLK_PS);
    localparam int TURN_CYC   = cyc_of(release_ps(GRADE_NS), CLK_PS);
    localparam int MAX_CYC    = imax(imax(imax(SETUP_CYC, STROBE_CYC), imax(HOLD_CYC, READ_CYC)), TURN_CYC);
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    ctrl_state_t      state;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             accept;
    logic             sample;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_access_fsm #(
        .CNT_W      (CNT_W),
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .READ_CYC   (READ_CYC),
        .TURN_CYC   (TURN_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (host_req),
        .req_we   (host_we),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .accept   (accept),
        .sample   (sample),
        .ready    (host_ready),
        .state    (state)
    );

    sram_host_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .sample   (sample),
        .addr_in  (host_addr),
        .wdata_in (host_wdata),
        .dq_in    (mem_dq_in),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_out),
        .rdata_q  (host_rdata)
    );

    // Decode memory control pins from the current phase.
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        case (state)
            ST_WSETUP, ST_WHOLD: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WSTROBE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_RWAIT: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sram_async_ctrl_chk.sv
// Checker: temporal rules on the memory pins and the ready pulse, attached
// to every sram_async_ctrl instance by the bind below.
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_strobe_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    assert_setup_before_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_dq_oe)));

    assert_hold_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe));

    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_release_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));

    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

    // Default build: 5 ns clock, 15 ns grade -> store strobe 3, load wait 3.
    localparam int WE_LOW  = 3;
    localparam int OE_LOW  = 3;
    localparam int WR_LAT  = 6;  // negedges from request to ready seen (5 edges after accept)
    localparam int RD_LAT  = 4;  // (3 edges after accept)
    localparam int RD_OK   = 2;  // model needs 3 cycles: counter reads 2 at the third edge

    typedef struct packed {
        logic        wr;
        logic [14:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 15'h0000, 8'hA5},
        '{1'b1, 15'h7FFF, 8'h5A},
        '{1'b1, 15'h1234, 8'h3C},
        '{1'b0, 15'h0000, 8'hA5},
        '{1'b0, 15'h7FFF, 8'h5A},
        '{1'b1, 15'h1234, 8'hC3},
        '{1'b0, 15'h1234, 8'hC3},
        '{1'b0, 15'h4000, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [14:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready;
    logic [7:0]  host_rdata;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sram_async_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---- memory model ----
    logic [7:0] model_mem [int];
    int rd_cnt = 0;

    always @(posedge mem_we_n)
        if (rst_n && !mem_ce_n && mem_dq_oe)
            model_mem[int'(mem_addr)] = mem_dq_out;

    always @(posedge clk)
        if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_cnt <= rd_cnt + 1;
        else rd_cnt <= 0;

    always @* begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n && rd_cnt >= RD_OK)
            mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = 8'hEE;
    end

    function automatic logic [7:0] peek(input logic [14:0] a);
        return model_mem.exists(int'(a)) ? model_mem[int'(a)] : 8'h00;
    endfunction

    // ---- pin monitors, sampled mid-cycle ----
    int we_run = 0, oe_run = 0, oe_high = 100, ce_low_cnt = 0;
    int bad_run_we = 0, bad_run_oe = 0, bad_setup = 0, bad_hold = 0;
    int bad_stable = 0, bad_cont = 0, bad_gap = 0, bad_overlap = 0;
    logic p_ce_n = 1'b1, p_we_n = 1'b1, p_dq_oe = 1'b0;
    logic [14:0] p_addr = '0;
    logic [7:0]  p_dout = '0;

    always @(negedge clk) if (rst_n) begin
        if (!mem_ce_n) ce_low_cnt++;
        if (!mem_we_n) we_run++;
        else if (we_run != 0) begin
            if (we_run != WE_LOW) bad_run_we++;                       // R2
            if (mem_ce_n || !mem_dq_oe) bad_hold++;                   // R3
            we_run = 0;
        end
        if (!mem_we_n && p_we_n && (p_ce_n || !p_dq_oe)) bad_setup++; // R3
        if (!mem_we_n && !mem_oe_n) bad_overlap++;                    // R2
        if (!mem_oe_n) begin
            oe_run++;
            oe_high = 0;
        end else begin
            if (oe_run != 0 && oe_run != OE_LOW) bad_run_oe++;        // R5
            oe_run = 0;
            if (oe_high < 100) oe_high++;
        end
        if (mem_dq_oe && !mem_oe_n) bad_cont++;                       // R6
        if (mem_dq_oe && !p_dq_oe && oe_high < 3) bad_gap++;          // R6
        if (!mem_ce_n && !p_ce_n && (mem_addr != p_addr || mem_dq_out != p_dout))
            bad_stable++;                                             // R4
        p_ce_n = mem_ce_n; p_we_n = mem_we_n; p_dq_oe = mem_dq_oe;
        p_addr = mem_addr; p_dout = mem_dq_out;
    end

    // Issue one request starting at a negedge; returns at the negedge ready is seen.
    task automatic do_access(input logic wr, input logic [14:0] a, input logic [7:0] d,
                             output int lat, output logic [7:0] rd);
        host_req = 1'b1; host_we = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        while (!host_ready && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        rd = host_rdata;
    endtask

    initial begin
        #500us;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R7 watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [7:0] rd;
        int ce_before;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset / idle state
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !host_ready, "R1",
              "idle pins {ce,oe,we,dq_oe,ready}",
              {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, host_ready}, 5'b11100);
        repeat (3) @(negedge clk);
        check(!host_ready && mem_ce_n, "R1", "idle stays quiet", {host_ready, mem_ce_n}, 2'b01);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            do_access(VECS[i].wr, VECS[i].addr, VECS[i].data, lat, rd);
            if (VECS[i].wr) begin
                check(lat == WR_LAT, "R7", "store latency", lat, WR_LAT);
                check(peek(VECS[i].addr) == VECS[i].data, "R2", "stored byte",
                      peek(VECS[i].addr), VECS[i].data);
            end else begin
                check(lat == RD_LAT, "R7", "load latency", lat, RD_LAT);
                check(rd == VECS[i].data, "R5", "load data", rd, VECS[i].data);
            end
            @(negedge clk);
            check(!host_ready, "R7", "ready one cycle", host_ready, 0);
            repeat (2) @(negedge clk);
        end

        // R8: request in a store's ready cycle is accepted at once
        do_access(1'b1, 15'h0ABC, 8'h77, lat, rd);
        check(lat == WR_LAT, "R7", "store latency before chained load", lat, WR_LAT);
        do_access(1'b0, 15'h0ABC, 8'h00, lat, rd);
        check(lat == RD_LAT, "R8", "chained load accepted immediately", lat, RD_LAT);
        check(rd == 8'h77, "R8", "chained load data", rd, 8'h77);

        // R8: request in a load's ready cycle is ignored
        ce_before = ce_low_cnt;
        host_req = 1'b1; host_we = 1'b1; host_addr = 15'h0000; host_wdata = 8'hFF;
        @(negedge clk);
        host_req = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (host_ready) check(1'b0, "R8", "ready after ignored request", 1, 0);
        end
        check(ce_low_cnt == ce_before, "R8", "memory cycles after ignored request",
              ce_low_cnt - ce_before, 0);
        check(peek(15'h0000) == 8'hA5, "R8", "contents after ignored request",
              peek(15'h0000), 8'hA5);

        // R6: store right after a load keeps the release gap
        do_access(1'b0, 15'h7FFF, 8'h00, lat, rd);
        check(rd == 8'h5A, "R5", "load before store", rd, 8'h5A);
        repeat (2) @(negedge clk);
        do_access(1'b1, 15'h7FFF, 8'h11, lat, rd);
        check(peek(15'h7FFF) == 8'h11, "R2", "store after load", peek(15'h7FFF), 8'h11);
        repeat (3) @(negedge clk);

        // Pin monitor summaries
        check(bad_run_we == 0, "R2", "strobe width errors", bad_run_we, 0);
        check(bad_overlap == 0, "R2", "strobe with output enable", bad_overlap, 0);
        check(bad_setup == 0, "R3", "setup before strobe errors", bad_setup, 0);
        check(bad_hold == 0, "R3", "hold after strobe errors", bad_hold, 0);
        check(bad_stable == 0, "R4", "bus changes while selected", bad_stable, 0);
        check(bad_run_oe == 0, "R5", "load wait width errors", bad_run_oe, 0);
        check(bad_cont == 0, "R6", "contention cycles", bad_cont, 0);
        check(bad_gap == 0, "R6", "release gap errors", bad_gap, 0);
        check(mem_ce_n && !mem_dq_oe, "R1", "idle at end", {mem_ce_n, mem_dq_oe}, 2'b10);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule